// File: doc/BRIEF.md
# SPI Control-Register Read Slave

This block is the serial front end that lets an external host read one byte from a bank of 32 control registers over a four-wire SPI link in mode 0. The host lowers chip select and clocks in a header byte. The top three bits of that byte are the command code, and the lower five bits name the register. The only command this block serves is the read, whose code is 000. Once the header is complete, the block issues a single-cycle read strobe to the register file. It latches the returned byte and shifts it out on the serial output, most significant bit first.

Each register belongs to one of two response classes. A per-address class map supplies the class for the active bank. Fast registers start their data on the first falling SCK edge after the last address bit. Slow registers first send eight zero bits, and the data byte follows them. Every SPI pin is synchronised into the system clock domain, and all decisions are taken on detected SCK edges. Raising chip select abandons whatever is in progress and turns the output driver off.

Top module: `spi_creg_read_slave`

## Requirements
- R1: Whenever synchronised chip select is high, `spi_so_oe` is 0 from the next system clock on. A transaction abandoned by raising chip select leaves no effect on the next one.
- R2: The first eight SI bits, each sampled on a rising SCK edge, form the header. Header bits 7:5 are the command, with 000 meaning read. Header bits 4:0 are the register address, sent MSb first.
- R3: For a read header, exactly one `rd_stb` pulse is issued, one system clock wide. It carries `rd_addr` equal to header bits 4:0 and `rd_bank` equal to `bank_sel`.
- R4: `rd_data` is taken in the second system clock after the strobe cycle, and that byte is the one shifted out.
- R5: If `slow_map[addr]` is 0 (fast class), the eight data bits appear MSb first on the eight falling SCK edges that follow the header.
- R6: If `slow_map[addr]` is 1 (slow class), eight 0 bits come first on those edges, and the data byte follows them MSb first.
- R7: `spi_so_oe` is 0 while the header is being received. It goes to 1 only on a falling SCK edge after a read header.
- R8: A header whose command is not 000 produces no strobe, and it keeps `spi_so_oe` at 0 until chip select rises.
- R9: Once the response byte is done, further SCK edges with chip select low drive 0 on `spi_so`, with `spi_so_oe` at 1.
- R10: `spi_so` changes only on falling SCK edges while it is driven.
- R11: A header cut short by chip select rising is discarded, and the next transaction decodes a fresh eight-bit header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host (idle low) |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data from host |
| bank_sel | input | BANK_W | Active register bank |
| slow_map | input | 2**ADDR_W | Class per address; 1 = slow (dummy byte first) |
| spi_so | output | 1 | Serial data to host |
| spi_so_oe | output | 1 | Output enable for the SO pad driver |
| rd_stb | output | 1 | Register read strobe, one cycle |
| rd_bank | output | BANK_W | Bank for the read |
| rd_addr | output | ADDR_W | Register address for the read |
| rd_data | input | DATA_W | Register byte, valid the cycle after the strobe |

## Verification
The case that needs care is chip select rising at the same moment that SCK falls during the data phase. In that cycle the abort and the output shift are both due. The bench provokes it by changing both pins in the same time step part-way through a slow-register response. Because the two synchroniser paths have equal depth, the edges arrive in the same cycle. The abort must win: the output enable drops, no extra strobe appears, and the next full read returns the correct byte with correct timing.

// File: rtl/spi_rcr_pkg.sv
package spi_rcr_pkg;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_HDR  = 2'd1,
    RS_DATA = 2'd2,
    RS_MUTE = 2'd3
  } rd_state_e;

  localparam logic [2:0] CMD_READ = 3'b000;

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [1:0] rs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_n_s = rs_q[1];
endmodule

// File: rtl/spi_pin_front.sv
module spi_pin_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic cs_n_in,
  input  logic si_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic si_s
);
  // lane order {si, cs_n, sck}; idle values with cs_n high
  localparam logic [2:0] IDLE_V = 3'b010;

  logic [STAGES-1:0][2:0] stg_q, stg_d;
  logic                   sck_last_q, sck_last_d;
  logic                   sck_s;

  always_comb begin
    stg_d      = {stg_q[STAGES-2:0], {si_in, cs_n_in, sck_in}};
    sck_last_d = stg_q[STAGES-1][0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q      <= {STAGES{IDLE_V}};
      sck_last_q <= 1'b0;
    end else begin
      stg_q      <= stg_d;
      sck_last_q <= sck_last_d;
    end
  end

  assign sck_s    = stg_q[STAGES-1][0];
  assign sck_rise = sck_s & ~sck_last_q;
  assign sck_fall = ~sck_s & sck_last_q;
  assign cs_act   = ~stg_q[STAGES-1][1];
  assign si_s     = stg_q[STAGES-1][2];
endmodule

// File: rtl/spi_hdr_ctrl.sv
module spi_hdr_ctrl
  import spi_rcr_pkg::*;
#(
  parameter int OPC_W  = 3,
  parameter int ADDR_W = 5,
  parameter int BANK_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_act,
  input  logic                     sck_rise,
  input  logic                     si_s,
  input  logic [BANK_W-1:0]        bank_sel,
  input  logic [(1<<ADDR_W)-1:0]   slow_map,
  output logic                     rd_stb,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic [BANK_W-1:0]        rd_bank,
  output logic                     load_req,
  output logic                     load_slow,
  output logic                     tx_en
);
  localparam int HDR_W = OPC_W + ADDR_W;
  localparam int CNT_W = $clog2(HDR_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(HDR_W - 1);

  rd_state_e          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [HDR_W-1:0]   hdr_q, hdr_d, hdr_full;
  logic               stb_q, stb_d;
  logic               ld_q, ld_d;
  logic               slow_q, slow_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [BANK_W-1:0]  bank_q, bank_d;

  assign hdr_full = {hdr_q[HDR_W-2:0], si_s};

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    hdr_d  = hdr_q;
    stb_d  = 1'b0;
    ld_d   = stb_q;
    slow_d = slow_q;
    addr_d = addr_q;
    bank_d = bank_q;
    if (!cs_act) begin
      st_d  = RS_IDLE;
      cnt_d = '0;
      ld_d  = 1'b0;
    end else begin
      unique case (st_q)
        RS_IDLE, RS_HDR: begin
          st_d = RS_HDR;
          if (sck_rise) begin
            hdr_d = hdr_full;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_d = '0;
              if (hdr_full[HDR_W-1 -: OPC_W] == CMD_READ) begin
                st_d   = RS_DATA;
                stb_d  = 1'b1;
                addr_d = hdr_full[ADDR_W-1:0];
                bank_d = bank_sel;
                slow_d = slow_map[hdr_full[ADDR_W-1:0]];
              end else begin
                st_d = RS_MUTE;
              end
            end
          end
        end
        RS_DATA: st_d = RS_DATA;
        RS_MUTE: st_d = RS_MUTE;
        default: st_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      cnt_q  <= '0;
      hdr_q  <= '0;
      stb_q  <= 1'b0;
      ld_q   <= 1'b0;
      slow_q <= 1'b0;
      addr_q <= '0;
      bank_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hdr_q  <= hdr_d;
      stb_q  <= stb_d;
      ld_q   <= ld_d;
      slow_q <= slow_d;
      addr_q <= addr_d;
      bank_q <= bank_d;
    end
  end

  assign rd_stb    = stb_q;
  assign rd_addr   = addr_q;
  assign rd_bank   = bank_q;
  assign load_req  = ld_q;
  assign load_slow = slow_q;
  assign tx_en     = (st_q == RS_DATA);
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              tx_en,
  input  logic              sck_fall,
  input  logic              load,
  input  logic              load_slow,
  input  logic [DATA_W-1:0] ld_data,
  output logic              so,
  output logic              so_oe
);
  localparam int SH_W = 2 * DATA_W;

  logic [SH_W-1:0] sh_q, sh_d, sh_fast, sh_slow;
  logic            so_q, so_d;
  logic            oe_q, oe_d;

  // fast: data leads; slow: a zero byte leads; zeros are shifted in behind
  assign sh_fast = {ld_data, {DATA_W{1'b0}}};
  assign sh_slow = {{DATA_W{1'b0}}, ld_data};

  always_comb begin
    sh_d = sh_q;
    so_d = so_q;
    oe_d = oe_q;
    if (!cs_act || !tx_en) begin
      oe_d = 1'b0;
      so_d = 1'b0;
    end else if (load) begin
      sh_d = load_slow ? sh_slow : sh_fast;
    end else if (sck_fall) begin
      so_d = sh_q[SH_W-1];
      sh_d = {sh_q[SH_W-2:0], 1'b0};
      oe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      so_q <= 1'b0;
      oe_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      so_q <= so_d;
      oe_q <= oe_d;
    end
  end

  assign so    = so_q;
  assign so_oe = oe_q;
endmodule

// File: rtl/spi_creg_read_slave.sv
module spi_creg_read_slave #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int OPC_W       = 3,
  parameter int BANK_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_sck,
  input  logic                   spi_cs_n,
  input  logic                   spi_si,
  input  logic [BANK_W-1:0]      bank_sel,
  input  logic [(1<<ADDR_W)-1:0] slow_map,
  output logic                   spi_so,
  output logic                   spi_so_oe,
  output logic                   rd_stb,
  output logic [BANK_W-1:0]      rd_bank,
  output logic [ADDR_W-1:0]      rd_addr,
  input  logic [DATA_W-1:0]      rd_data
);
  logic rst_n_s;
  logic sck_rise, sck_fall, cs_act, si_s;
  logic load_req, load_slow, tx_en;

  spi_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  spi_pin_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sck_in   (spi_sck),
    .cs_n_in  (spi_cs_n),
    .si_in    (spi_si),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_act   (cs_act),
    .si_s     (si_s)
  );

  spi_hdr_ctrl #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_act    (cs_act),
    .sck_rise  (sck_rise),
    .si_s      (si_s),
    .bank_sel  (bank_sel),
    .slow_map  (slow_map),
    .rd_stb    (rd_stb),
    .rd_addr   (rd_addr),
    .rd_bank   (rd_bank),
    .load_req  (load_req),
    .load_slow (load_slow),
    .tx_en     (tx_en)
  );

  spi_tx_shift #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_act    (cs_act),
    .tx_en     (tx_en),
    .sck_fall  (sck_fall),
    .load      (load_req),
    .load_slow (load_slow),
    .ld_data   (rd_data),
    .so        (spi_so),
    .so_oe     (spi_so_oe)
  );
endmodule

// File: rtl/spi_rcr_read_chk.sv
module spi_rcr_read_chk (
  input logic clk,
  input logic rst_n_s,
  input logic cs_act,
  input logic sck_fall,
  input logic spi_so,
  input logic spi_so_oe,
  input logic rd_stb
);
  // R1: select released -> driver off on the following cycle
  assert_oe_off_idle_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cs_act |=> !spi_so_oe);

  // R3: strobe is a single-cycle pulse
  assert_stb_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_stb |=> !rd_stb);

  // R7: nothing is driven while the read is still being issued
  assert_quiet_at_stb_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_stb |-> !spi_so_oe);

  // R7: driver turns on only as a result of a falling SCK edge
  assert_oe_rise_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(spi_so_oe) |-> $past(sck_fall));

  // R10: driven output only moves after a falling SCK edge
  assert_so_moves_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (spi_so_oe && $past(spi_so_oe) && !$past(sck_fall)) |-> $stable(spi_so));
endmodule

bind spi_creg_read_slave spi_rcr_read_chk u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .cs_act    (cs_act),
  .sck_fall  (sck_fall),
  .spi_so    (spi_so),
  .spi_so_oe (spi_so_oe),
  .rd_stb    (rd_stb)
);

// File: tb/spi_creg_read_slave_tb.sv
module spi_creg_read_slave_tb;
  localparam int HALF = 10; // system clocks per SCK half period

  logic        clk, rst_n;
  logic        sck, cs_n, si;
  logic [1:0]  bank_sel;
  logic [31:0] slow_map;
  logic        so, so_oe, rd_stb;
  logic [1:0]  rd_bank;
  logic [4:0]  rd_addr;
  logic [7:0]  rd_data;

  int n_chk, n_bad;
  int stb_cnt;
  logic [4:0]  stb_addr;
  logic [1:0]  stb_bank;
  logic [23:0] rx;
  int oe_hdr, oe_rx;
  bit done;

  spi_creg_read_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .bank_sel(bank_sel), .slow_map(slow_map), .spi_so(so), .spi_so_oe(so_oe),
    .rd_stb(rd_stb), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] data_of(input logic [1:0] b, input logic [4:0] a);
    return 8'(({6'd0, b} * 8'd71) ^ ({3'd0, a} * 8'd29) ^ 8'h5A);
  endfunction

  function automatic logic [31:0] map_of(input logic [1:0] b);
    logic [63:0] w;
    w = {32'h9A3C65F1, 32'h9A3C65F1} >> (b * 5);
    return w[31:0];
  endfunction

  // register file model: data valid the cycle after the strobe
  always @(posedge clk) begin
    if (rd_stb) begin
      stb_cnt  = stb_cnt + 1;
      stb_addr = rd_addr;
      stb_bank = rd_bank;
    end
    rd_data <= data_of(rd_bank, rd_addr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // sends nhdr header bits, then clocks nrx bits while sampling SO before each rise
  task automatic xfer(input logic [7:0] hdr, input int nhdr, input int nrx);
    rx = '0; oe_hdr = 0; oe_rx = 0;
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nhdr; i++) begin
      si = hdr[7-i];
      wait_clk(HALF);
      if (so_oe) oe_hdr++;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
    for (int j = 0; j < nrx; j++) begin
      wait_clk(HALF);
      rx = {rx[22:0], so};
      if (so_oe) oe_rx++;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic end_cs;
    wait_clk(HALF);
    cs_n = 1'b1;
    si   = 1'b0;
    wait_clk(2 * HALF);
  endtask

  task automatic full_read(input logic [1:0] b, input logic [4:0] a);
    logic [7:0]  d;
    logic        slow;
    logic [23:0] exp;
    bank_sel = b;
    slow_map = map_of(b);
    d    = data_of(b, a);
    slow = slow_map[a];
    stb_cnt = 0;
    xfer({3'b000, a}, 8, 24);
    end_cs();
    exp = slow ? {8'h00, d, 8'h00} : {d, 16'h0000};
    chk(oe_hdr == 0, "R7 oe during header", 32'(oe_hdr), 0);
    chk(oe_rx == 24, "R7 oe during response", 32'(oe_rx), 24);
    chk(stb_cnt == 1 && stb_addr == a && stb_bank == b, "R2 R3 strobe count/addr/bank",
        {stb_cnt[7:0], 3'b0, stb_addr, 6'b0, stb_bank}, {8'd1, 3'b0, a, 6'b0, b});
    if (slow) chk(rx == exp, "R6 R4 R10 slow response", 32'(rx), 32'(exp));
    else      chk(rx == exp, "R5 R4 R10 fast response", 32'(rx), 32'(exp));
    chk((slow ? rx[7:0] : rx[15:0]) == '0, "R9 trailing zeros", 32'(rx), 32'(exp));
    chk(so_oe == 1'b0, "R1 oe after release", 32'(so_oe), 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; stb_cnt = 0; done = 0;
    stb_addr = '0; stb_bank = '0;
    sck = 0; cs_n = 1; si = 0; bank_sel = 0; slow_map = 0;
    rst_n = 0;
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);
    chk(so_oe == 0 && rd_stb == 0, "R1 reset state", {so_oe, rd_stb}, 0);

    // full sweep: every bank, every address, mixed classes
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 32; a++)
        full_read(2'(b), 5'(a));

    // R8: non-read commands stay silent
    for (int op = 1; op < 8; op++) begin
      stb_cnt = 0;
      xfer({3'(op), 5'd3}, 8, 16);
      end_cs();
      chk(oe_hdr == 0 && oe_rx == 0, "R8 no drive on other command", 32'(oe_rx), 0);
      chk(stb_cnt == 0, "R8 no strobe on other command", 32'(stb_cnt), 0);
    end

    // R11: header cut after 4 bits, then a fresh read
    stb_cnt = 0;
    xfer(8'hFF, 4, 0);
    end_cs();
    chk(stb_cnt == 0 && so_oe == 0, "R11 partial header discarded", 32'(stb_cnt), 0);
    full_read(2'd1, 5'd7);

    // R1: select release coinciding with a falling SCK in the data phase
    bank_sel = 2'd2;
    slow_map = 32'hFFFF_FFFF;
    stb_cnt = 0;
    xfer({3'b000, 5'd19}, 8, 10);
    wait_clk(HALF);
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
    cs_n = 1'b1;
    wait_clk(6);
    chk(so_oe == 0, "R1 abort wins over shift", 32'(so_oe), 0);
    chk(stb_cnt == 1, "R1 R3 single strobe through abort", 32'(stb_cnt), 1);
    wait_clk(2 * HALF);
    full_read(2'd2, 5'd19);
    full_read(2'd0, 5'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule